// File: doc/BRIEF.md
# Two-Channel Memory-to-Memory Copy Engine

This block copies a block of bytes from one memory region to another without the CPU handling the data. Each byte takes two cycles. In the first cycle the engine reads the source byte into an internal holding register. In the next cycle it writes that byte to the destination. Channel 0 holds the source address and channel 1 holds the destination address. Channel 1 also holds the word count. Each address steps up or down after every byte, as its mode bit selects.

The CPU programs the engine through a small register port. Writing an address or count register loads the base copy and the working copy together. Setting the enable bit starts the copy. The count runs down past zero. The byte that takes it from zero to all-ones is the last one, so a programmed count N moves N+1 bytes.

On that last byte the engine pulses its end-of-process output and sets a sticky completion flag. It then either stops, or reloads its working registers from the base copies and starts the block again.

Top module: `dma_m2m`

## Requirements
- R1: Every byte moves as a read cycle (mem_re high) followed directly by a write cycle (mem_we high). The two strobes are never high together, and mem_wdata in the write cycle is the byte returned by mem_rdata in the read cycle before it.
- R2: The read cycle presents the channel 0 working address on mem_addr. The write cycle presents the channel 1 working address.
- R3: At the end of each write cycle, each working address steps by one. It steps down when its mode bit is set and up when it is clear. The source mode is control bit 1 and the destination mode is control bit 2.
- R4: The channel 1 working count drops by one after each byte. The transfer ends on the byte where the count goes from 0 to 16'hFFFF, so a programmed count N moves N+1 bytes.
- R5: eop is high for exactly one cycle, which is the write cycle of the final byte.
- R6: The register map on cpu_addr is:
  - 0: control. Bit 0 is enable, bit 1 is source down-count, bit 2 is destination down-count, bit 3 is auto-initialize.
  - 1, 2, 3: write loads the base and working copies of the source address, destination address and count. Read returns the working copy.
  - 4: status. Bit 0 is the completion flag.
  - 5, 6, 7: read the base copies of the source address, destination address and count.
- R7: The base copies do not change during a transfer.
- R8: Without auto-initialize, the engine clears the enable bit at the end of the block and makes no further memory access until enable is written again. The working registers keep their final values.
- R9: With auto-initialize, the working addresses and count reload from the base copies at the end of the block and enable stays set. The very next cycle is a read at the base source address.
- R10: The completion flag sets at the end of each block. A CPU read of the status register clears it.
- R11: After reset, every register reads zero and there is no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_re | input | 1 | CPU register read strobe (clears the completion flag on the status register) |
| cpu_addr | input | 3 | CPU register select |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data (combinational) |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the read cycle |
| eop | output | 1 | End-of-process pulse |

## Verification
Random blocks mix all four combinations of up-counting and down-counting sources and destinations. Opposite directions tell a swapped or ignored mode bit apart from a correct one, because the copied image then lands in reverse or at the wrong end. Directed cases cover a count of zero, where a single byte must move, and lengths up to thirty, where an off-by-one in terminal count shows up as one byte too many or too few in the write tally. An auto-initialize run checks that the cycle after the pulse reads from the base source and that a second block follows unaided. Runs without it check that memory stays silent afterwards.

// File: rtl/dma_m2m_pkg.sv
package dma_m2m_pkg;

   typedef enum logic [2:0] {
      RA_CTRL  = 3'd0,
      RA_SRC   = 3'd1,
      RA_DST   = 3'd2,
      RA_CNT   = 3'd3,
      RA_STAT  = 3'd4,
      RA_SRC_B = 3'd5,
      RA_DST_B = 3'd6,
      RA_CNT_B = 3'd7
   } reg_addr_e;

   typedef struct packed {
      logic auto_init;
      logic dst_dec;
      logic src_dec;
      logic enable;
   } ctrl_t;

   typedef enum logic {
      PH_READ  = 1'b0,
      PH_WRITE = 1'b1
   } phase_e;

endpackage

// File: rtl/dma_addr_chan.sv
// Base/working register pair with a one-step walker.
module dma_addr_chan #(
   parameter int W         = 16,
   parameter bit ALLOW_DEC = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         reload,
   input  logic         step,
   input  logic         dec,
   output logic [W-1:0] base_q,
   output logic [W-1:0] cur_q
);

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] nxt;

   generate
      if (ALLOW_DEC) begin : g_updown
         assign nxt = dec ? (cur_q - ONE) : (cur_q + ONE);
      end else begin : g_uponly
         logic unused_dec;
         assign unused_dec = dec;
         assign nxt = cur_q + ONE;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cur_q  <= '0;
      end else if (load) begin
         base_q <= load_val;
         cur_q  <= load_val;
      end else if (reload) begin
         cur_q <= base_q;
      end else if (step) begin
         cur_q <= nxt;
      end
   end

endmodule

// File: rtl/dma_m2m_seq.sv
// Read/write phase sequencer and byte holding register.
module dma_m2m_seq
   import dma_m2m_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          restart,
   input  logic [DW-1:0] rd_data,
   output logic          rd_cyc,
   output logic          wr_cyc,
   output logic [DW-1:0] hold_q
);

   phase_e ph_q;

   assign rd_cyc = enable && (ph_q == PH_READ);
   assign wr_cyc = enable && (ph_q == PH_WRITE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ph_q <= PH_READ;
      else if (!enable || restart) ph_q <= PH_READ;
      else if (ph_q == PH_READ)    ph_q <= PH_WRITE;
      else                         ph_q <= PH_READ;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hold_q <= '0;
      else if (rd_cyc) hold_q <= rd_data;
   end

endmodule

// File: rtl/dma_m2m.sv
module dma_m2m
   import dma_m2m_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int DW = 8,
   parameter bit ALLOW_DEC = 1'b1,
   localparam int RW = (AW > CW) ? AW : CW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_we,
   input  logic          cpu_re,
   input  logic [2:0]    cpu_addr,
   input  logic [RW-1:0] cpu_wdata,
   output logic [RW-1:0] cpu_rdata,
   output logic          mem_re,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          eop
);

   localparam int CTRL_W = $bits(ctrl_t);

   generate
      if (AW < 2) begin : g_bad_aw
         $error("dma_m2m: AW must be at least 2");
      end
      if (CW < 1) begin : g_bad_cw
         $error("dma_m2m: CW must be at least 1");
      end
      if (DW < 1) begin : g_bad_dw
         $error("dma_m2m: DW must be at least 1");
      end
      if (RW < CTRL_W) begin : g_bad_rw
         $error("dma_m2m: register width too small for control");
      end
   endgenerate

   ctrl_t          ctrl_q;
   logic           tc_flag;
   logic           auto_en;
   logic           rd_cyc, wr_cyc, tc;
   logic [DW-1:0]  hold_q;
   logic [AW-1:0]  src_base, src_cur, dst_base, dst_cur;
   logic [CW-1:0]  cnt_base, cnt_cur;
   logic           wr_ctrl, wr_src, wr_dst, wr_cnt, rd_stat;

   assign wr_ctrl = cpu_we && (cpu_addr == RA_CTRL);
   assign wr_src  = cpu_we && (cpu_addr == RA_SRC);
   assign wr_dst  = cpu_we && (cpu_addr == RA_DST);
   assign wr_cnt  = cpu_we && (cpu_addr == RA_CNT);
   assign rd_stat = cpu_re && (cpu_addr == RA_STAT);
   assign auto_en = ctrl_q.auto_init;

   dma_m2m_seq #(.DW(DW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (ctrl_q.enable),
      .restart (wr_ctrl),
      .rd_data (mem_rdata),
      .rd_cyc  (rd_cyc),
      .wr_cyc  (wr_cyc),
      .hold_q  (hold_q)
   );

   assign tc = wr_cyc && (cnt_cur == '0);

   dma_addr_chan #(.W(AW), .ALLOW_DEC(ALLOW_DEC)) u_src (
      .clk(clk), .rst_n(rst_n), .load(wr_src), .load_val(cpu_wdata[AW-1:0]),
      .reload(tc && auto_en), .step(wr_cyc), .dec(ctrl_q.src_dec),
      .base_q(src_base), .cur_q(src_cur)
   );

   dma_addr_chan #(.W(AW), .ALLOW_DEC(ALLOW_DEC)) u_dst (
      .clk(clk), .rst_n(rst_n), .load(wr_dst), .load_val(cpu_wdata[AW-1:0]),
      .reload(tc && auto_en), .step(wr_cyc), .dec(ctrl_q.dst_dec),
      .base_q(dst_base), .cur_q(dst_cur)
   );

   dma_addr_chan #(.W(CW), .ALLOW_DEC(1'b1)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(wr_cnt), .load_val(cpu_wdata[CW-1:0]),
      .reload(tc && auto_en), .step(wr_cyc), .dec(1'b1),
      .base_q(cnt_base), .cur_q(cnt_cur)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ctrl_q <= '0;
      else if (wr_ctrl)        ctrl_q <= ctrl_t'(cpu_wdata[CTRL_W-1:0]);
      else if (tc && !auto_en) ctrl_q.enable <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tc_flag <= 1'b0;
      else if (tc)      tc_flag <= 1'b1;
      else if (rd_stat) tc_flag <= 1'b0;
   end

   always_comb begin
      unique case (reg_addr_e'(cpu_addr))
         RA_CTRL:  cpu_rdata = RW'(ctrl_q);
         RA_SRC:   cpu_rdata = RW'(src_cur);
         RA_DST:   cpu_rdata = RW'(dst_cur);
         RA_CNT:   cpu_rdata = RW'(cnt_cur);
         RA_STAT:  cpu_rdata = RW'(tc_flag);
         RA_SRC_B: cpu_rdata = RW'(src_base);
         RA_DST_B: cpu_rdata = RW'(dst_base);
         RA_CNT_B: cpu_rdata = RW'(cnt_base);
         default:  cpu_rdata = '0;
      endcase
   end

   assign mem_re    = rd_cyc;
   assign mem_we    = wr_cyc;
   assign mem_addr  = wr_cyc ? dst_cur : src_cur;
   assign mem_wdata = hold_q;
   assign eop       = tc;

endmodule

// File: rtl/dma_m2m_chk.sv
module dma_m2m_chk #(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cpu_we,
   input logic          mem_re,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic          eop,
   input logic          auto_en,
   input logic          tc_flag,
   input logic [AW-1:0] src_base,
   input logic [CW-1:0] cnt_cur
);

   // R1
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we));

   // R1
   wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(mem_re));

   // R4
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !cpu_we) |=> (cnt_cur == $past(cnt_cur) - CW'(1)) || auto_en);

   // R5
   eop_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eop |-> mem_we);

   // R5
   eop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eop |=> !eop);

   // R8
   stop_after_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eop && !auto_en && !cpu_we) |=> (!mem_re && !mem_we));

   // R9
   reload_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eop && auto_en && !cpu_we) |=> (mem_re && mem_addr == $past(src_base)));

   // R10
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eop |=> tc_flag);

endmodule

bind dma_m2m dma_m2m_chk #(.AW(AW), .CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_we   (cpu_we),
   .mem_re   (mem_re),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .eop      (eop),
   .auto_en  (auto_en),
   .tc_flag  (tc_flag),
   .src_base (src_base),
   .cnt_cur  (cnt_cur)
);

// File: tb/tb_dma_m2m.sv
`timescale 1ns/1ps
module tb_dma_m2m;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_we = 1'b0, cpu_re = 1'b0;
   logic [2:0]  cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic [15:0] cpu_rdata;
   logic        mem_re, mem_we, eop;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;

   int checks = 0, errors = 0;
   int wr_count = 0, eop_count = 0;
   bit done = 1'b0;

   logic [7:0] mem [256];
   logic [7:0] fill_img [256];
   logic [7:0] exp_img [256];
   logic       tb_fill = 1'b0;

   always #4 clk = ~clk;

   dma_m2m dut (
      .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_re(cpu_re),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .eop(eop)
   );

   always @(posedge clk) begin
      if (tb_fill) begin
         for (int i = 0; i < 256; i++) mem[i] <= fill_img[i];
      end else if (mem_we) begin
         mem[mem_addr[7:0]] <= mem_wdata;
      end
   end
   assign mem_rdata = mem[mem_addr[7:0]];

   always @(negedge clk) begin
      if (mem_we) wr_count++;
      if (eop)    eop_count++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cpu_wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_we = 1'b0;
   endtask

   task automatic cpu_rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      cpu_re = 1'b1; cpu_addr = a;
      #1 d = cpu_rdata;
      @(negedge clk);
      cpu_re = 1'b0;
   endtask

   task automatic load_mem();
      @(negedge clk);
      tb_fill = 1'b1;
      @(negedge clk);
      tb_fill = 1'b0;
   endtask

   function automatic logic [15:0] walk(input logic [15:0] b, input bit dn, input int k);
      return dn ? b - 16'(k) : b + 16'(k);
   endfunction

   task automatic wait_eops(input int target);
      int guard = 0;
      while (eop_count < target && guard < 4000) begin
         @(posedge clk);
         guard++;
      end
      #1;
      chk("R5 end pulse seen", 32'(eop_count >= target), 32'd1);
   endtask

   task automatic cmp_mem(input string req);
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== exp_img[i]) bad++;
      chk(req, bad, 0);
   endtask

   task automatic run_block(input logic [15:0] src, input logic [15:0] dst,
                            input logic [15:0] cnt, input bit sdn, input bit ddn);
      logic [15:0] v;
      int n;
      n = int'(cnt) + 1;
      for (int i = 0; i < 256; i++) begin
         fill_img[i] = 8'($urandom);
         exp_img[i]  = fill_img[i];
      end
      for (int k = 0; k < n; k++)
         exp_img[walk(dst, ddn, k) & 16'hFF] = fill_img[walk(src, sdn, k) & 16'hFF];
      load_mem();
      cpu_wr(3'd1, src);
      cpu_wr(3'd2, dst);
      cpu_wr(3'd3, cnt);
      cpu_rd(3'd1, v); chk("R6 src working load", v, src);
      cpu_rd(3'd6, v); chk("R6 dst base load", v, dst);
      cpu_rd(3'd3, v); chk("R6 count working load", v, cnt);
      wr_count = 0; eop_count = 0;
      cpu_wr(3'd0, {12'd0, 1'b0, ddn, sdn, 1'b1});
      wait_eops(1);
      repeat (4) @(negedge clk);
      chk("R4 bytes moved", wr_count, n);
      chk("R5 single pulse", eop_count, 1);
      chk("R8 idle after end", {31'd0, mem_re | mem_we}, 0);
      cmp_mem("R1 R2 R3 copied image");
      cpu_rd(3'd0, v); chk("R8 enable cleared", {16'd0, v}, {28'd0, 1'b0, ddn, sdn, 1'b0});
      cpu_rd(3'd1, v); chk("R3 src final", v, walk(src, sdn, n));
      cpu_rd(3'd2, v); chk("R3 dst final", v, walk(dst, ddn, n));
      cpu_rd(3'd3, v); chk("R4 count rolled", v, 16'hFFFF);
      cpu_rd(3'd5, v); chk("R7 src base kept", v, src);
      cpu_rd(3'd7, v); chk("R7 count base kept", v, cnt);
      cpu_rd(3'd4, v); chk("R10 flag set", v, 16'd1);
      cpu_rd(3'd4, v); chk("R10 flag cleared", v, 16'd0);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      chk("R11 no access", {30'd0, mem_re, mem_we}, 0);
      cpu_rd(3'd0, v); chk("R11 ctrl zero", v, 0);
      cpu_rd(3'd1, v); chk("R11 src zero", v, 0);
      cpu_rd(3'd3, v); chk("R11 count zero", v, 0);
      cpu_rd(3'd4, v); chk("R11 status zero", v, 0);

      // directed: single byte, then reverse directions
      run_block(16'h1240, 16'h34B0, 16'd0, 1'b0, 1'b0);
      run_block(16'h0050, 16'h00D0, 16'd15, 1'b1, 1'b1);
      run_block(16'hA03C, 16'h77AA, 16'd29, 1'b0, 1'b1);

      // random blocks
      for (int r = 0; r < 6; r++) begin
         run_block({8'($urandom), 8'(40 + $urandom_range(0, 40))},
                   {8'($urandom), 8'(170 + $urandom_range(0, 40))},
                   16'($urandom_range(0, 29)),
                   1'($urandom), 1'($urandom));
      end

      // R9 auto-initialize: two blocks then stop
      begin
         logic [15:0] s, d, c;
         s = 16'h2044; d = 16'h20C8; c = 16'd9;
         for (int i = 0; i < 256; i++) begin
            fill_img[i] = 8'($urandom);
            exp_img[i]  = fill_img[i];
         end
         for (int k = 0; k <= 9; k++) exp_img[(d + 16'(k)) & 16'hFF] = fill_img[(s + 16'(k)) & 16'hFF];
         load_mem();
         cpu_wr(3'd1, s); cpu_wr(3'd2, d); cpu_wr(3'd3, c);
         wr_count = 0; eop_count = 0;
         cpu_wr(3'd0, 16'h0009);
         wait_eops(1);
         chk("R9 restart read", {31'd0, mem_re}, 1);
         chk("R9 restart at base src", mem_addr, s);
         wait_eops(2);
         cpu_wr(3'd0, 16'h0000);
         repeat (3) @(negedge clk);
         chk("R9 two full blocks", wr_count, 20);
         cmp_mem("R9 image after repeat");
         cpu_rd(3'd1, v); chk("R9 src reloaded", v, s);
         cpu_rd(3'd3, v); chk("R9 count reloaded", v, c);
         cpu_rd(3'd4, v); chk("R10 flag after auto", v, 16'd1);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule